// File: doc/BRIEF.md
# Incremental Multiply-Table Fill Sequencer

This block loads three product lookup tables, each of which maps an 11-bit magnitude k to floor(k·c / 2048) for a constant c that is fixed for the frame. There is one table for each of the x, y and z components of the light vector. The block does not use a multiplier. Each table keeps one 22-bit error accumulator. The accumulator starts at zero, and the table's constant is added to it once per address. Whenever the low 11-bit error field overflows, the carry raises the upper 11-bit field by one. That upper field is the stored value, so the division by 2048 costs no logic.

A single start pulse launches a complete pass. The block first latches the three constants. It then issues one RAM write per clock: address 0 through 2047 of the x table, then the y table, then the z table. After the final write it raises a one-cycle done flag. A full pass takes 6144 clocks, which is roughly 370 µs at a 60 ns clock and fits within a vertical retrace interval. The tables hold only product magnitudes. Sign handling stays with the shading datapath that reads them later.

Top module: `mtf_fill_seq`

## Requirements
- R1: Address 0 of every table receives the value 0.
- R2: Address k of table t receives floor(k·c_t / 2048), where c_t is the 11-bit constant captured for that table. As a consequence, consecutive entries within one table differ by 0 or 1.
- R3: Tables are filled in the order x (select 0), y (select 1), z (select 2). Within each table the addresses rise from 0 to 2047 without a gap.
- R4: Every cycle of a pass carries exactly one write with `we_o` high. `we_o` is low whenever no pass is running, and the table select never exceeds 2.
- R5: `done_o` goes high for exactly one cycle, in the cycle right after the write to z address 2047. `we_o` is low in that cycle.
- R6: A start pulse that arrives during a pass is ignored, and the write sequence continues without a break.
- R7: The three constants are sampled in the cycle in which a start is accepted. Later changes on the constant inputs do not affect the pass that is already running.
- R8: One pass consists of exactly 6144 writes.
- R9: While reset is held and after it is released, `we_o` and `done_o` are low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| const_x_i | input | 11 | Multiplier constant for the x table |
| const_y_i | input | 11 | Multiplier constant for the y table |
| const_z_i | input | 11 | Multiplier constant for the z table |
| we_o | output | 1 | RAM write enable |
| tbl_o | output | 2 | Table select: 0 = x, 1 = y, 2 = z |
| addr_o | output | 11 | RAM write address |
| data_o | output | 11 | RAM write data |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
Some properties are checked by assertions on every cycle. These cover the zero at each table's base address and the step of 0 or 1 between neighbouring entries. They also cover the fact that a start pulse during a pass only advances the address, the position of the done pulse right after the final z write, and the range of the table select. Other behaviour can only be shown by the bench scenarios, which compare every write against floor(k·c/2048) computed from the captured constants. Those scenarios cover the exact product values for extreme constants (0, 1, 1024, 2047), the total write count, and the fact that constants changed mid-pass are not picked up.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int unsigned NUM_TBL = 3;
  localparam int unsigned TBL_W   = 2;
  typedef enum logic [TBL_W-1:0] {
    TBL_X = 2'd0,
    TBL_Y = 2'd1,
    TBL_Z = 2'd2
  } tbl_e;
endpackage

// File: rtl/mtf_walker.sv
module mtf_walker
  import mtf_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              wrap_o,
  output tbl_e              tbl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic last_addr, last_tbl;

  assign last_addr = &addr_o;
  assign last_tbl  = (tbl_o == TBL_Z);
  assign load_o    = start_i & ~busy_o;
  assign wrap_o    = busy_o & last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tbl_o  <= TBL_X;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        tbl_o  <= TBL_X;
        addr_o <= '0;
      end else if (busy_o) begin
        addr_o <= addr_o + 1'b1;
        if (last_addr) begin
          if (last_tbl) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            tbl_o  <= TBL_X;
          end else begin
            tbl_o <= tbl_e'(tbl_o + 1'b1);
          end
        end
      end
    end
  end

  p_done_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last_addr && last_tbl) |=> (done_o && !busy_o));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last_addr) |=> (busy_o && addr_o == $past(addr_o) + 1'b1
                                           && tbl_o == $past(tbl_o)));
  p_tbl_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tbl_o <= TBL_Z));
endmodule

// File: rtl/mtf_accum.sv
module mtf_accum
  import mtf_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FRAC_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] consts_i [NUM_TBL],
  input  logic              busy_i,
  input  logic              wrap_i,
  input  tbl_e              tbl_i,
  output logic [ADDR_W-1:0] data_o
);
  localparam int unsigned ACC_W = ADDR_W + FRAC_W;

  logic [FRAC_W-1:0] const_q [NUM_TBL];
  logic [ACC_W-1:0]  acc_q;
  logic [FRAC_W-1:0] step;

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_const
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     const_q[g] <= '0;
      else if (load_i) const_q[g] <= consts_i[g];
    end
  end

  assign step = const_q[tbl_i];

  // combined accumulator: low FRAC_W bits are the error, carry bumps the value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  acc_q <= '0;
    else if (!busy_i || wrap_i)   acc_q <= '0;
    else                          acc_q <= acc_q + ACC_W'(step);
  end

  assign data_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/mtf_fill_seq.sv
module mtf_fill_seq
  import mtf_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FRAC_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FRAC_W-1:0] const_x_i,
  input  logic [FRAC_W-1:0] const_y_i,
  input  logic [FRAC_W-1:0] const_z_i,
  output logic              we_o,
  output logic [TBL_W-1:0]  tbl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] data_o,
  output logic              done_o
);
  logic              busy, load, wrap;
  tbl_e              tbl;
  logic [FRAC_W-1:0] consts [NUM_TBL];

  assign consts[0] = const_x_i;
  assign consts[1] = const_y_i;
  assign consts[2] = const_z_i;

  mtf_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy),
    .load_o (load),
    .wrap_o (wrap),
    .tbl_o  (tbl),
    .addr_o (addr_o),
    .done_o (done_o)
  );

  mtf_accum #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .consts_i(consts),
    .busy_i  (busy),
    .wrap_i  (wrap),
    .tbl_i   (tbl),
    .data_o  (data_o)
  );

  assign we_o  = busy;
  assign tbl_o = tbl;

  p_zero_base_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && addr_o == '0) |-> (data_o == '0));
  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && addr_o != '0) |-> (data_o == $past(data_o) || data_o == $past(data_o) + 1'b1));
  p_no_write_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !we_o);
endmodule

// File: tb/tb_mtf_fill_seq.sv
module tb_mtf_fill_seq;
  localparam int ADDR_W = 11;
  localparam int FRAC_W = 11;
  localparam int NWR    = 3 * (1 << ADDR_W);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [FRAC_W-1:0] const_x_i = '0, const_y_i = '0, const_z_i = '0;
  logic              we_o, done_o;
  logic [1:0]        tbl_o;
  logic [ADDR_W-1:0] addr_o, data_o;

  int errors = 0, checks = 0, wr_cnt = 0;

  mtf_fill_seq #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  // behavioural reference, advanced on each rising edge
  int m_busy = 0, m_done = 0, m_k = 0, m_t = 0;
  int m_c [3];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_k = 0; m_t = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (m_k == (1 << ADDR_W) - 1) begin
          m_k = 0;
          if (m_t == 2) begin m_busy = 0; m_done = 1; m_t = 0; end
          else m_t++;
        end else m_k++;
      end else if (start_i) begin
        m_busy = 1; m_k = 0; m_t = 0;
        m_c[0] = int'(const_x_i); m_c[1] = int'(const_y_i); m_c[2] = int'(const_z_i);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(we_o == (m_busy != 0), "R4 we_o", int'(we_o), m_busy);
      chk(done_o == (m_done != 0), "R5 done_o", int'(done_o), m_done);
      if (m_busy != 0) begin
        int exp_d;
        exp_d = (m_k * m_c[m_t]) / 2048;
        chk(int'(tbl_o) == m_t, "R3 tbl_o", int'(tbl_o), m_t);
        chk(int'(addr_o) == m_k, "R3 addr_o", int'(addr_o), m_k);
        if (m_k == 0) chk(data_o == '0, "R1 base data", int'(data_o), 0);
        else chk(int'(data_o) == exp_d, "R2 data", int'(data_o), exp_d);
      end
      if (we_o) wr_cnt++;
    end
  end

  task automatic run_fill(input int cx, input int cy, input int cz, input bit disturb);
    @(negedge clk_i);
    const_x_i = FRAC_W'(cx); const_y_i = FRAC_W'(cy); const_z_i = FRAC_W'(cz);
    wr_cnt = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < NWR + 20; n++) begin
      @(negedge clk_i);
      if (disturb && n == 100) begin
        start_i = 1'b1;   // R6: ignored mid-pass
        const_x_i = 11'd7; const_y_i = 11'd2000; const_z_i = 11'd3;  // R7: not sampled
      end
      if (disturb && n == 101) start_i = 1'b0;
      if (done_o) break;
    end
    @(negedge clk_i);
    chk(wr_cnt == NWR, "R8 write count", wr_cnt, NWR);
    chk(!we_o && !done_o, "R5 idle after done", int'(we_o), 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!we_o && !done_o, "R9 reset outputs", int'(we_o) + int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!we_o && !done_o, "R9 idle after reset", int'(we_o) + int'(done_o), 0);
    run_fill(0, 2047, 1024, 1'b0);   // R1 R2 extremes
    run_fill(1, 683, 1365, 1'b1);    // R6 R7 disturbed pass
    chk(m_c[0] == 1 && m_c[2] == 1365, "R7 model constants", m_c[0], 1);
    run_fill(2046, 5, 1023, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule